// File: doc/BRIEF.md
# Bus-Armed Watchdog Timer

This block supervises software through a single byte-wide register on a simple I/O bus. Software arms it by writing a nonzero scale byte, which also sets the allowed silence to that byte times a base interval (a parameter in clock cycles, about 1.6 s on silicon and a few cycles in simulation). From then on, any read of the register counts as a kick and restarts the interval. The value returned by the read does not matter to the kick. Writing zero stands the watchdog down.

If the interval runs out while armed, the block fires once and then disarms itself until software writes it again. A fired timeout becomes one of two things, chosen by two configuration inputs. By default it is a reset pulse of fixed width. It can instead be an interrupt request level. The output can also be suppressed entirely. Reads return the current scale byte, so software can confirm what it set.

Top module: `wdog_top`

## Requirements
- R1: After reset the watchdog is disarmed, `bus_rdata` reads 0 and both `wd_reset` and `wd_irq` are low.
- R2: A write access (`bus_sel`=1, `bus_wr`=1) with nonzero `bus_wdata` arms the watchdog; from the next cycle `bus_rdata` returns that byte.
- R3: With no further access, an armed watchdog with scale F times out so that the selected output rises right after the clock edge F*BASE_CYCLES cycles after the arming edge.
- R4: A read access (`bus_sel`=1, `bus_wr`=0) restarts the full interval from that edge and leaves the scale byte unchanged; `bus_rdata` shows the scale during the read.
- R5: Writing 0x00 disarms the watchdog: `bus_rdata` reads 0 from the next cycle and no timeout follows.
- R6: Writing a new nonzero scale while armed replaces the scale and restarts the interval from that write.
- R7: In reset mode (`out_en`=1, `irq_mode`=0) a timeout drives `wd_reset` high for exactly PULSE_CYCLES cycles.
- R8: On a timeout the watchdog disarms itself: `bus_rdata` reads 0 and no further timeout occurs without a new write.
- R9: In interrupt mode (`out_en`=1, `irq_mode`=1) a timeout raises `wd_irq` instead of `wd_reset`; it stays high until the next port access of either kind, which clears it from the next cycle.
- R10: With `out_en`=0 a timeout drives neither output but still disarms the watchdog.
- R11: `wd_reset` and `wd_irq` are never high together; an interrupt timeout that lands during an active reset pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write access, 0 = read access (kick) |
| bus_wdata | input | FACTOR_W | Scale byte for writes; 0 disarms |
| bus_rdata | output | FACTOR_W | Current scale byte, 0 when disarmed |
| out_en | input | 1 | 1 = timeouts reach an output, 0 = suppressed |
| irq_mode | input | 1 | 1 = timeout raises interrupt, 0 = timeout pulses reset |
| wd_reset | output | 1 | Active-high reset pulse on timeout |
| wd_irq | output | 1 | Interrupt request level on timeout |

## Verification
A stale unit counter or a prescaler that misses a restart shows as a timeout edge landing on the wrong cycle, so every expected firing is tied to an exact cycle number relative to the arming or kicking edge, and a missed kick is caught the moment an unexpected edge appears, at most one interval later. A scale register that is not cleared on firing or on a zero write shows on the very next read of `bus_rdata`. A wrong pulse counter shows in the measured width of `wd_reset` within PULSE_CYCLES cycles of its rise, and a wrong output route shows as the wrong pin rising at the timeout cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Where a timeout is sent, picked from the configuration inputs.
  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_RESET = 2'd1,
    ROUTE_IRQ   = 2'd2
  } wd_route_e;

  function automatic wd_route_e pick_route(input logic en, input logic irq_sel);
    if (!en)          return ROUTE_NONE;
    else if (irq_sel) return ROUTE_IRQ;
    else              return ROUTE_RESET;
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned BASE_CYCLES = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);

  localparam int unsigned CW = (BASE_CYCLES > 2) ? $clog2(BASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BASE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick   = run && !restart && (cnt_q == LAST);
  assign cnt_en = restart || run || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run) cnt_d = '0;
    else if (tick)       cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned FACTOR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic                rd_stb,
  input  logic [FACTOR_W-1:0] wdata,
  input  logic                tick,
  output logic [FACTOR_W-1:0] factor_o,
  output logic                armed_o,
  output logic                restart_o,
  output logic                expire_o
);

  logic [FACTOR_W-1:0] factor_q, factor_d;
  logic [FACTOR_W-1:0] units_q, units_d;
  logic                access;
  logic                last_unit;
  logic                reg_en;

  assign access    = wr_stb || rd_stb;
  assign armed_o   = (factor_q != '0);
  assign last_unit = (units_q == (factor_q - FACTOR_W'(1)));
  assign expire_o  = armed_o && tick && last_unit && !access;
  assign restart_o = access;
  assign factor_o  = factor_q;
  assign reg_en    = access || tick;

  always_comb begin
    factor_d = factor_q;
    units_d  = units_q;
    if (wr_stb) begin
      factor_d = wdata;
      units_d  = '0;
    end else if (rd_stb) begin
      units_d  = '0;
    end else if (expire_o) begin
      factor_d = '0;
      units_d  = '0;
    end else if (tick && armed_o) begin
      units_d  = units_q + FACTOR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      factor_q <= '0;
      units_q  <= '0;
    end else if (reg_en) begin
      factor_q <= factor_d;
      units_q  <= units_d;
    end
  end

endmodule

// File: rtl/wdog_signal.sv
module wdog_signal
  import wdog_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic access,
  input  logic out_en,
  input  logic irq_mode,
  output logic wd_reset,
  output logic wd_irq
);

  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] LOAD = PW'(PULSE_CYCLES);

  wd_route_e     route;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pulse_on;
  logic          irq_q, irq_d;
  logic          pcnt_en;

  assign route    = pick_route(out_en, irq_mode);
  assign pulse_on = (pcnt_q != '0);
  assign pcnt_en  = fire || pulse_on;

  always_comb begin
    pcnt_d = pcnt_q;
    if (fire && route == ROUTE_RESET) pcnt_d = LOAD;
    else if (pulse_on)                pcnt_d = pcnt_q - PW'(1);
  end

  always_comb begin
    irq_d = irq_q;
    if (fire && route == ROUTE_RESET)                 irq_d = 1'b0;
    else if (fire && route == ROUTE_IRQ && !pulse_on) irq_d = 1'b1;
    else if (access)                                  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign wd_reset = pulse_on;
  assign wd_irq   = irq_q;

endmodule

// File: rtl/wdog_top.sv
module wdog_top #(
  parameter int unsigned FACTOR_W     = 8,
  parameter int unsigned BASE_CYCLES  = 400_000_000,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [FACTOR_W-1:0] bus_wdata,
  output logic [FACTOR_W-1:0] bus_rdata,
  input  logic                out_en,
  input  logic                irq_mode,
  output logic                wd_reset,
  output logic                wd_irq
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       wr_stb, rd_stb;
  logic       tick, armed, restart, expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && !bus_wr;

  wdog_prescaler #(.BASE_CYCLES(BASE_CYCLES)) u_prescaler (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .run     (armed),
    .tick    (tick)
  );

  wdog_core #(.FACTOR_W(FACTOR_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .wdata     (bus_wdata),
    .tick      (tick),
    .factor_o  (bus_rdata),
    .armed_o   (armed),
    .restart_o (restart),
    .expire_o  (expire)
  );

  wdog_signal #(.PULSE_CYCLES(PULSE_CYCLES)) u_signal (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fire     (expire),
    .access   (bus_sel),
    .out_en   (out_en),
    .irq_mode (irq_mode),
    .wd_reset (wd_reset),
    .wd_irq   (wd_irq)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned FACTOR_W     = 8,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [FACTOR_W-1:0] bus_wdata,
  input logic [FACTOR_W-1:0] bus_rdata,
  input logic                out_en,
  input logic                irq_mode,
  input logic                wd_reset,
  input logic                wd_irq
);

  int unsigned hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= 0;
    else if (wd_reset) hi_cnt <= hi_cnt + 1;
    else               hi_cnt <= 0;
  end

  a_r11_outputs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_reset && wd_irq));

  a_r2_write_loads_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata != '0) |=> (bus_rdata == $past(bus_wdata)));

  a_r5_zero_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata == '0) |=> (bus_rdata == '0));

  a_r4_read_keeps_scale: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> (bus_rdata == $past(bus_rdata)));

  a_r8_fire_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset) |-> (bus_rdata == '0));

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq && !bus_sel) |=> wd_irq);

  a_r9_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_irq && bus_sel) |=> !wd_irq);

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_reset) |-> (hi_cnt >= PULSE_CYCLES));

endmodule

bind wdog_top wdog_checker #(
  .FACTOR_W     (FACTOR_W),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_wdog_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .out_en    (out_en),
  .irq_mode  (irq_mode),
  .wd_reset  (wd_reset),
  .wd_irq    (wd_irq)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;

  localparam int B = 8;
  localparam int P = 4;

  typedef struct {
    int cyc;
    bit is_irq;
  } ev_t;

  logic       clk;
  logic       rst_n;
  logic       bus_sel;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       out_en;
  logic       irq_mode;
  logic       wd_reset;
  logic       wd_irq;

  int  cyc;
  int  n_chk;
  int  n_fail;
  bit  done;
  ev_t exp_q[$];

  wdog_top #(.FACTOR_W(8), .BASE_CYCLES(B), .PULSE_CYCLES(P)) i_wdog_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .out_en    (out_en),
    .irq_mode  (irq_mode),
    .wd_reset  (wd_reset),
    .wd_irq    (wd_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic bus_write(input logic [7:0] d, output int e0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1 e0 = cyc;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(output logic [7:0] d, output int e0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 e0 = cyc;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_event(input int at, input bit irq);
    ev_t e;
    e.cyc = at;
    e.is_irq = irq;
    exp_q.push_back(e);
  endtask

  // Monitor: every rising edge of an output must match the head of the queue.
  logic prev_rst, prev_irq;
  int   hi_len;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_rst <= 1'b0; prev_irq <= 1'b0; hi_len <= 0;
    end else begin
      if ((wd_reset && !prev_rst) || (wd_irq && !prev_irq)) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R5/R8/R10 unexpected timeout", cyc, -1);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(cyc == e.cyc, "R3/R6 timeout cycle", cyc, e.cyc);
          check(wd_irq == e.is_irq, "R9 output route irq", int'(wd_irq), int'(e.is_irq));
          check(wd_reset == !e.is_irq, "R7 output route reset", int'(wd_reset), int'(!e.is_irq));
        end
      end
      if (wd_reset) hi_len <= hi_len + 1;
      else begin
        if (prev_rst) check(hi_len == P, "R7 pulse width", hi_len, P);
        hi_len <= 0;
      end
      prev_rst <= wd_reset;
      prev_irq <= wd_irq;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before end of test");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int         e0;
    logic [7:0] rd;
    cyc = 0; n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    out_en = 1'b1; irq_mode = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1: reset state
    check(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 0);
    check(!wd_reset && !wd_irq, "R1 outputs low after reset", {wd_reset, wd_irq}, 0);

    // R2, R3, R7, R8: arm with scale 3 and let it expire
    bus_write(8'h03, e0);
    check(bus_rdata == 8'h03, "R2 scale readback", bus_rdata, 3);
    expect_event(e0 + 3*B, 1'b0);
    idle(3*B + 2*P + 4);
    check(bus_rdata == 8'h00, "R8 disarmed after timeout", bus_rdata, 0);
    idle(5*B); // R8: no second firing

    // R4: a read kick restarts the interval
    bus_write(8'h05, e0);
    idle(30);
    bus_read(rd, e0);
    check(rd == 8'h05, "R4 read returns scale", rd, 5);
    check(bus_rdata == 8'h05, "R4 scale kept after read", bus_rdata, 5);
    expect_event(e0 + 5*B, 1'b0);
    idle(5*B + P + 6);

    // R6: rewrite while armed restarts with new scale
    bus_write(8'h0A, e0);
    idle(30);
    bus_write(8'h02, e0);
    check(bus_rdata == 8'h02, "R6 new scale readback", bus_rdata, 2);
    expect_event(e0 + 2*B, 1'b0);
    idle(2*B + P + 40);

    // R5: writing zero disarms
    bus_write(8'h04, e0);
    idle(10);
    bus_write(8'h00, e0);
    check(bus_rdata == 8'h00, "R5 rdata after zero write", bus_rdata, 0);
    idle(6*B);

    // R4: repeated kicks keep an armed watchdog quiet
    bus_write(8'h02, e0);
    for (int k = 0; k < 6; k++) begin
      idle(8);
      bus_read(rd, e0);
    end
    check(rd == 8'h02, "R4 scale after kicks", rd, 2);
    bus_write(8'h00, e0);
    idle(4*B);

    // R9, R11: interrupt mode
    irq_mode = 1'b1;
    bus_write(8'h02, e0);
    expect_event(e0 + 2*B, 1'b1);
    idle(2*B + 20);
    check(wd_irq == 1'b1, "R9 irq held", wd_irq, 1);
    check(wd_reset == 1'b0, "R11 no reset in irq mode", wd_reset, 0);
    bus_read(rd, e0);
    check(rd == 8'h00, "R8 disarmed after irq timeout", rd, 0);
    check(wd_irq == 1'b0, "R9 irq cleared by access", wd_irq, 1'b0);

    // R10: output suppressed, still disarms
    out_en = 1'b0; irq_mode = 1'b0;
    bus_write(8'h01, e0);
    idle(B + 10);
    check(bus_rdata == 8'h00, "R10 disarmed with output off", bus_rdata, 0);
    check(!wd_reset && !wd_irq, "R10 outputs quiet", {wd_reset, wd_irq}, 0);
    out_en = 1'b1;
    idle(4);

    check(exp_q.size() == 0, "R3 all expected timeouts seen", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule